// File: doc/BRIEF.md
# Receive frame statistics counters

This block keeps the hardware statistics for a receive path. Once per received frame the datapath presents an event carrying two lengths (with and without the 4-byte frame check sequence) and two control bits: one that permits long frames and one that keeps bad frames. The block sorts the frame into a size bin, advances the packet and octet totals, and decides whether the frame is oversized and must be dropped. An oversized frame advances only its own counter.

Every counter saturates at its all-ones value instead of wrapping. All counters are visible through a combinational read port addressed by a small index. The 64-bit octet total is split across two read words. A read returns the value held before any update that lands in the same clock cycle.

Top module: `rx_frame_stats`

## Requirements
- R1: A counted frame increments exactly one size bin, chosen by its length including the check sequence (`evt_len_fcs`). The bins and their read addresses are: 64 exactly (address 0), 65 to 127 (1), 128 to 255 (2), 256 to 511 (3), 512 to 1023 (4), and 1024 or more (5).
- R2: A counted frame whose `evt_len_fcs` is below 64 increments no size bin.
- R3: Every counted frame increments the total packet counter (address 6). The good packet word (address 7) always reads the same value as the total.
- R4: Every counted frame adds `evt_len_data + 4` to the octet counter. The low read word (address 8) and the high read word (address 9) hold its lower and upper `RD_W` bits. The good-octet words (addresses 10 and 11) mirror them.
- R5: Every counter holds at its all-ones value instead of wrapping, and the octet counter holds at all-ones when an addition would carry out.
- R6: `evt_drop` is high for a valid event when `evt_len_fcs` exceeds 16384, or when it exceeds 1522 and `ctl_long_en` is low. In both cases `ctl_keep_bad` must be low.
- R7: A dropped frame increments the oversize counter (address 12). With `ctl_keep_bad` high, no frame is dropped and the oversize counter is unchanged.
- R8: A dropped frame leaves the size bins, the packet counters and the octet counter unchanged.
- R9: After reset every counter reads 0. `rd_data` is a combinational view of the addressed counter, so a read in the cycle of an event shows the value before that event. Addresses 13 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One frame event this cycle |
| evt_len_fcs | input | LEN_W | Frame length including check sequence |
| evt_len_data | input | LEN_W | Frame length without check sequence |
| ctl_long_en | input | 1 | Long frames up to 16384 allowed |
| ctl_keep_bad | input | 1 | Never drop for size |
| evt_drop | output | 1 | Event is oversized and dropped |
| rd_addr | input | 4 | Counter read index |
| rd_data | output | RD_W | Addressed counter value |

## Verification
The bench first steps one frame across each bin edge: 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023 and 1024. This separates off-by-one errors in the bin edges and shows that runt frames reach no bin. It then tries lengths just above 1522 and 16384 with every combination of long-enable and keep-bad. This pulls apart the two oversize limits, the override, and the freezing of the other counters on a drop. A long mixed sweep of lengths with narrow counters drives the packet and bin counters into saturation. A burst of large frames saturates the octet counter across its two read words. This separates holding at the limit from wrapping.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   localparam int NUM_BINS = 6;
   localparam int NUM_REGS = 13;
   localparam int ADDR_W   = $clog2(NUM_REGS);

   typedef enum logic [ADDR_W-1:0] {
      A_BIN64   = 4'd0,
      A_BIN127  = 4'd1,
      A_BIN255  = 4'd2,
      A_BIN511  = 4'd3,
      A_BIN1023 = 4'd4,
      A_BINMAX  = 4'd5,
      A_TOTAL   = 4'd6,
      A_GOOD    = 4'd7,
      A_OCT_LO  = 4'd8,
      A_OCT_HI  = 4'd9,
      A_GOCT_LO = 4'd10,
      A_GOCT_HI = 4'd11,
      A_OVERSZ  = 4'd12
   } reg_addr_e;

   // Lowest length (with check sequence) that falls into bin b.
   function automatic int bin_floor(input int b);
      case (b)
         0:       return 64;
         1:       return 65;
         2:       return 128;
         3:       return 256;
         4:       return 512;
         default: return 1024;
      endcase
   endfunction
endpackage

// File: rtl/rxs_sat_cnt.sv
module rxs_sat_cnt #(
   parameter int W     = 32,
   parameter int AMT_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [AMT_W-1:0] amt,
   output logic [W-1:0]     q
);
   logic [W-1:0] q_nxt;

   if (AMT_W > W + 1) begin : g_bad_amt
      $error("rxs_sat_cnt: AMT_W too wide for W");
   end

   if (AMT_W == 1) begin : g_unit
      // Increment-by-one variant: compare against all-ones, no carry chain reuse.
      always_comb begin
         q_nxt = q;
         if (inc && amt[0] && (q != {W{1'b1}})) q_nxt = q + 1'b1;
      end
   end else begin : g_add
      logic [W:0] sum;
      always_comb begin
         sum   = {1'b0, q} + (W+1)'(amt);
         q_nxt = q;
         if (inc) q_nxt = sum[W] ? {W{1'b1}} : sum[W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end
endmodule

// File: rtl/rxs_classify.sv
module rxs_classify
   import rxs_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int STD_MAX  = 1522,
   parameter int LONG_MAX = 16384
) (
   input  logic [LEN_W-1:0]    len_fcs,
   input  logic                long_en,
   input  logic                keep_bad,
   output logic [NUM_BINS-1:0] bin_hit,
   output logic                oversize
);
   localparam logic [LEN_W-1:0] STD_L  = LEN_W'(STD_MAX);
   localparam logic [LEN_W-1:0] LONG_L = LEN_W'(LONG_MAX);

   if ((1 << LEN_W) <= LONG_MAX) begin : g_bad_len
      $error("rxs_classify: LEN_W cannot hold LONG_MAX");
   end

   for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
      localparam logic [LEN_W-1:0] LO = LEN_W'(bin_floor(b));
      if (b == 0) begin : g_exact
         assign bin_hit[b] = (len_fcs == LO);
      end else if (b == NUM_BINS - 1) begin : g_top
         assign bin_hit[b] = (len_fcs >= LO);
      end else begin : g_mid
         localparam logic [LEN_W-1:0] HI = LEN_W'(bin_floor(b + 1));
         assign bin_hit[b] = (len_fcs >= LO) && (len_fcs < HI);
      end
   end

   assign oversize = !keep_bad &&
                     ((len_fcs > LONG_L) || (!long_en && (len_fcs > STD_L)));
endmodule

// File: rtl/rx_frame_stats.sv
module rx_frame_stats
   import rxs_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int CNT_W    = 32,
   parameter int OCT_W    = 64,
   parameter int RD_W     = 32,
   parameter int STD_MAX  = 1522,
   parameter int LONG_MAX = 16384
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [LEN_W-1:0]  evt_len_fcs,
   input  logic [LEN_W-1:0]  evt_len_data,
   input  logic              ctl_long_en,
   input  logic              ctl_keep_bad,
   output logic              evt_drop,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [RD_W-1:0]   rd_data
);
   localparam int OCT_AMT_W = LEN_W + 1;
   localparam int RD2_W     = 2 * RD_W;

   if (CNT_W > RD_W) begin : g_bad_cnt
      $error("rx_frame_stats: CNT_W wider than RD_W");
   end
   if (OCT_W > RD2_W || OCT_W < OCT_AMT_W) begin : g_bad_oct
      $error("rx_frame_stats: OCT_W out of range");
   end

   logic [NUM_BINS-1:0]  bin_hit;
   logic                 oversize;
   logic                 count_en;
   logic [OCT_AMT_W-1:0] oct_amt;
   logic [CNT_W-1:0]     bin_q [NUM_BINS];
   logic [CNT_W-1:0]     total_q;
   logic [CNT_W-1:0]     ovr_q;
   logic [OCT_W-1:0]     oct_q;
   logic [RD2_W-1:0]     oct_ext;

   rxs_classify #(
      .LEN_W   (LEN_W),
      .STD_MAX (STD_MAX),
      .LONG_MAX(LONG_MAX)
   ) u_classify (
      .len_fcs (evt_len_fcs),
      .long_en (ctl_long_en),
      .keep_bad(ctl_keep_bad),
      .bin_hit (bin_hit),
      .oversize(oversize)
   );

   assign evt_drop = evt_valid && oversize;
   assign count_en = evt_valid && !oversize;
   assign oct_amt  = {1'b0, evt_len_data} + OCT_AMT_W'(4);

   for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin_cnt
      rxs_sat_cnt #(.W(CNT_W), .AMT_W(1)) u_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .inc  (count_en && bin_hit[b]),
         .amt  (1'b1),
         .q    (bin_q[b])
      );
   end

   rxs_sat_cnt #(.W(CNT_W), .AMT_W(1)) u_total (
      .clk(clk), .rst_n(rst_n), .inc(count_en), .amt(1'b1), .q(total_q)
   );

   rxs_sat_cnt #(.W(CNT_W), .AMT_W(1)) u_oversz (
      .clk(clk), .rst_n(rst_n), .inc(evt_drop), .amt(1'b1), .q(ovr_q)
   );

   rxs_sat_cnt #(.W(OCT_W), .AMT_W(OCT_AMT_W)) u_octets (
      .clk(clk), .rst_n(rst_n), .inc(count_en), .amt(oct_amt), .q(oct_q)
   );

   assign oct_ext = RD2_W'(oct_q);

   always_comb begin
      rd_data = '0;
      for (int b = 0; b < NUM_BINS; b++) begin
         if (rd_addr == ADDR_W'(b)) rd_data = RD_W'(bin_q[b]);
      end
      case (rd_addr)
         A_TOTAL,   A_GOOD:    rd_data = RD_W'(total_q);
         A_OCT_LO,  A_GOCT_LO: rd_data = oct_ext[RD_W-1:0];
         A_OCT_HI,  A_GOCT_HI: rd_data = oct_ext[RD2_W-1:RD_W];
         A_OVERSZ:             rd_data = RD_W'(ovr_q);
         default: ;
      endcase
   end
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
   import rxs_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                evt_valid,
   input logic                ctl_keep_bad,
   input logic                evt_drop,
   input logic [NUM_BINS-1:0] bin_hit,
   input logic [CNT_W-1:0]    total_q,
   input logic [CNT_W-1:0]    ovr_q
);
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   p_bin_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bin_hit));

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (total_q == FULL) |=> (total_q == FULL));

   p_total_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !evt_drop && total_q != FULL) |=> (total_q == $past(total_q) + 1'b1));

   p_drop_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_drop |=> $stable(total_q));

   p_oversz_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_drop && ovr_q != FULL) |=> (ovr_q == $past(ovr_q) + 1'b1));

   p_keep_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_keep_bad |-> !evt_drop);
endmodule

bind rx_frame_stats rxs_checker #(.CNT_W(CNT_W)) i_rxs_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_valid   (evt_valid),
   .ctl_keep_bad(ctl_keep_bad),
   .evt_drop    (evt_drop),
   .bin_hit     (bin_hit),
   .total_q     (total_q),
   .ovr_q       (ovr_q)
);

// File: tb/test_rx_frame_stats.sv
module test_rx_frame_stats;
   localparam int LEN_W = 16;
   localparam int CNT_W = 8;
   localparam int OCT_W = 20;
   localparam int RD_W  = 16;
   localparam longint CNT_MAX = (64'd1 << CNT_W) - 1;
   localparam longint OCT_MAX = (64'd1 << OCT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             evt_valid = 1'b0;
   logic [LEN_W-1:0] evt_len_fcs = '0;
   logic [LEN_W-1:0] evt_len_data = '0;
   logic             ctl_long_en = 1'b0;
   logic             ctl_keep_bad = 1'b0;
   logic             evt_drop;
   logic [3:0]       rd_addr = '0;
   logic [RD_W-1:0]  rd_data;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   longint e_bin [6];
   longint e_tot, e_ovr, e_oct;

   always #10 clk = ~clk;

   rx_frame_stats #(
      .LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W), .RD_W(RD_W)
   ) i_rx_frame_stats (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid),
      .evt_len_fcs(evt_len_fcs), .evt_len_data(evt_len_data),
      .ctl_long_en(ctl_long_en), .ctl_keep_bad(ctl_keep_bad),
      .evt_drop(evt_drop), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint exp_reg(input int a);
      case (a)
         0, 1, 2, 3, 4, 5: return e_bin[a];
         6, 7:             return e_tot;
         8, 10:            return e_oct & 64'hffff;
         9, 11:            return e_oct >> 16;
         12:               return e_ovr;
         default:          return 0;
      endcase
   endfunction

   function automatic string addr_tag(input int a);
      if (a < 6)  return "R1 bin";
      if (a < 8)  return "R3 packets";
      if (a < 12) return "R4 octets";
      if (a == 12) return "R7 oversize";
      return "R9 unused";
   endfunction

   task automatic check_all(input string ctx);
      for (int a = 0; a < 16; a++) begin
         rd_addr = 4'(a);
         #1;
         check($sformatf("%s %s addr=%0d", ctx, addr_tag(a), a), longint'(rd_data), exp_reg(a));
      end
   endtask

   function automatic int bin_of(input int len);
      if (len == 64)   return 0;
      if (len < 64)    return -1;
      if (len < 128)   return 1;
      if (len < 256)   return 2;
      if (len < 512)   return 3;
      if (len < 1024)  return 4;
      return 5;
   endfunction

   // One frame: drive at negedge, check pre-update read and drop, update model.
   task automatic frame(input string ctx, input int len, input bit long_en,
                        input bit keep_bad, input bit full_check);
      bit over;
      int b;
      @(negedge clk);
      evt_valid    = 1'b1;
      evt_len_fcs  = LEN_W'(len);
      evt_len_data = LEN_W'(len - 4);
      ctl_long_en  = long_en;
      ctl_keep_bad = keep_bad;
      rd_addr      = 4'd6;
      over = !keep_bad && ((len > 16384) || (!long_en && len > 1522));
      #5;
      check({ctx, " R9 pre-update total"}, longint'(rd_data), e_tot);
      check({ctx, " R6 drop flag"}, longint'(evt_drop), longint'(over));
      if (over) begin
         if (e_ovr < CNT_MAX) e_ovr++;
      end else begin
         b = bin_of(len);
         if (b >= 0 && e_bin[b] < CNT_MAX) e_bin[b]++;
         if (e_tot < CNT_MAX) e_tot++;
         e_oct = (e_oct + len > OCT_MAX) ? OCT_MAX : e_oct + len;
      end
      @(negedge clk);
      evt_valid = 1'b0;
      if (full_check) check_all(ctx);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 6; i++) e_bin[i] = 0;
      e_tot = 0; e_ovr = 0; e_oct = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R9 reset");

      frame("R2 runt 63", 63, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 64", 64, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 65", 65, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 127", 127, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 128", 128, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 255", 255, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 256", 256, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 511", 511, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 512", 512, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 1023", 1023, 1'b0, 1'b0, 1'b1);
      frame("R1 edge 1024", 1024, 1'b0, 1'b0, 1'b1);
      frame("R6 std limit 1522", 1522, 1'b0, 1'b0, 1'b1);
      frame("R8 std over 1523", 1523, 1'b0, 1'b0, 1'b1);
      frame("R6 long 1523", 1523, 1'b1, 1'b0, 1'b1);
      frame("R6 long limit 16384", 16384, 1'b1, 1'b0, 1'b1);
      frame("R8 long over 16385", 16385, 1'b1, 1'b0, 1'b1);
      frame("R7 keep 16385", 16385, 1'b1, 1'b1, 1'b1);
      frame("R7 keep 2000", 2000, 1'b0, 1'b1, 1'b1);
      frame("R8 over 40000", 40000, 1'b0, 1'b0, 1'b1);

      for (int len = 40; len < 1700; len += 3)
         frame("R5 sweep", len, len[0], (len % 5) == 0, (len % 31) == 0);
      check_all("R5 after sweep");

      for (int i = 0; i < 70; i++)
         frame("R5 octet burst", 16000, 1'b1, 1'b0, 1'b0);
      check_all("R5 octet saturate");

      for (int i = 0; i < 300; i++)
         frame("R5 oversize burst", 20000, 1'b1, 1'b0, 1'b0);
      check_all("R5 oversize saturate");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule